// File: doc/BRIEF.md
# Timed Microsequence Controller

This block runs short register-transfer routines as a chain of timed steps. A one-hot step counter advances through t1, t2 and so on for the routine that was launched. Every register bit is loaded from an OR of product terms. Each term is the AND of three or four things: the flag of the running routine, the source bit, any control flip-flop that gates the step, and the decoded step time. When no term is true, the register keeps its value. One more step after the last transfer returns the counter to idle, so the next routine starts again at t1.

Two routines are built in. The fetch routine reads the next instruction: it copies the program counter to the memory address register, loads the memory word at that address into the instruction buffer, and then increments the program counter. The work routine loads two operands, adds them and compares the sum. It then takes one of two branches on the compare flag: a right shift, or an AND-then-OR that goes through a temporary register. It finishes by swapping two registers through the temporary register and writing one of them to memory. The memory sits outside the block. Its address comes from the memory address register, and its read data is used in the same cycle.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous reset clears all step bits and both routine flags (idle). It also clears every register and the compare flag, and holds `done`, `busy` and `mem_we` low.
- R2: A `start` seen while idle with `sel`=0 runs fetch with one transfer per step. At t1 the memory address register takes the program counter. At t2 the instruction buffer takes `mem_rdata`, read at `mem_addr`. At t3 the program counter takes its value plus one, wrapping at the data width.
- R3: A `start` seen while idle with `sel`=1 runs the work routine. At t1 B takes the instruction buffer and C takes the program counter. At t2 A takes B+C, modulo 2^W. At t3 the flag takes 1 if A equals C, else 0.
- R4: At t4 the flag selects the branch. When the flag is 1, B takes A shifted right by one with a zero fill. When the flag is 0, the temporary register takes A AND B, and at t5 C takes that temporary value OR C.
- R5: The last three transfers swap A and B through the temporary register. At t6 the temporary register takes A, at t7 A takes B, and at t8 B takes the temporary register. Also at t8, `mem_we` is high with `mem_wdata` equal to A and `mem_addr` equal to the memory address register.
- R6: `done` is high for exactly one cycle, in the step after the last transfer: t4 for fetch and t9 for the work routine. In the next cycle the counter is idle (`tstep`=0, `busy`=0), and a new `start` there begins at t1.
- R7: `start` is ignored while `busy` is high, including the `done` cycle. The running routine keeps its timing and its transfers.
- R8: `tstep` is one-hot while busy and zero while idle. Bit k-1 stands for step tk, so bit 0 is t1.
- R9: A register keeps its value in every cycle in which none of its load terms is true. No two load terms for the same register are ever true in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request, taken only while idle |
| sel | input | 1 | Routine select: 0 fetch, 1 work |
| mem_rdata | input | W | Memory read data for `mem_addr`, same cycle |
| mem_addr | output | W | Memory address (memory address register) |
| mem_wdata | output | W | Memory write data (register A) |
| mem_we | output | 1 | Memory write enable |
| pc | output | W | Program counter |
| ibuf | output | W | Instruction buffer |
| ra | output | W | Register A |
| rb | output | W | Register B |
| rc | output | W | Register C |
| flag | output | 1 | Compare flip-flop |
| tstep | output | 9 | One-hot step time, bit 0 = t1 |
| busy | output | 1 | A routine is active |
| done | output | 1 | Completion step of the running routine |

## Verification
A start sampled on one edge makes t1 visible after that edge. The transfer of step tk shows in the registers after the next edge, so it appears one cycle after `tstep` shows tk. `done` appears four cycles after the launch edge for fetch and nine cycles after it for the work routine. The reference model applies each step's transfer on the same rising edge as the design, and every output is compared on the falling edge that follows. This means every result is checked in the first cycle it is due and in every later cycle. Separate counts of the cycles from launch to `done` confirm the routine lengths, including a run in which a second start arrives mid-routine.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         sel,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic         mem_we,
  output logic [W-1:0] pc,
  output logic [W-1:0] ibuf,
  output logic [W-1:0] ra,
  output logic [W-1:0] rb,
  output logic [W-1:0] rc,
  output logic         flag,
  output logic [8:0]   tstep,
  output logic         busy,
  output logic         done
);
  localparam int NSTEP = 9;
  localparam int FETCH_END = 3;
  localparam int WORK_END = NSTEP - 1;

  logic [NSTEP-1:0] t;
  logic sf, sx;
  logic [W-1:0] mar, rt;

  wire idle = ~|t;
  wire fin  = (sf & t[FETCH_END]) | (sx & t[WORK_END]);

  always_ff @(posedge clk) begin
    if (rst) begin
      t <= '0; sf <= 1'b0; sx <= 1'b0;
    end else if (idle) begin
      if (start) begin
        t <= NSTEP'(1); sf <= ~sel; sx <= sel;
      end
    end else if (fin) begin
      t <= '0; sf <= 1'b0; sx <= 1'b0;
    end else begin
      t <= t << 1;
    end
  end

  wire f1 = sf & t[0];
  wire f2 = sf & t[1];
  wire f3 = sf & t[2];
  wire x1 = sx & t[0];
  wire x2 = sx & t[1];
  wire x3 = sx & t[2];
  wire x4t = sx & t[3] & flag;
  wire x4f = sx & t[3] & ~flag;
  wire x5f = sx & t[4] & ~flag;
  wire x6 = sx & t[5];
  wire x7 = sx & t[6];
  wire x8 = sx & t[7];

  wire [W-1:0] bus = ({W{f1}} & pc) | ({W{x1}} & ibuf);
  wire [W-1:0] sum = rb + rc;
  wire [W-1:0] inc = pc + W'(1);

  wire [W-1:0] mar_d  = ({W{f1}} & bus) | ({W{~f1}} & mar);
  wire [W-1:0] ibuf_d = ({W{f2}} & mem_rdata) | ({W{~f2}} & ibuf);
  wire [W-1:0] pc_d   = ({W{f3}} & inc) | ({W{~f3}} & pc);
  wire [W-1:0] ra_d   = ({W{x2}} & sum) | ({W{x7}} & rb)
                      | ({W{~(x2 | x7)}} & ra);
  wire [W-1:0] rb_d   = ({W{x1}} & bus) | ({W{x4t}} & (ra >> 1))
                      | ({W{x8}} & rt) | ({W{~(x1 | x4t | x8)}} & rb);
  wire [W-1:0] rc_d   = ({W{x1}} & pc) | ({W{x5f}} & (rt | rc))
                      | ({W{~(x1 | x5f)}} & rc);
  wire [W-1:0] rt_d   = ({W{x4f}} & (ra & rb)) | ({W{x6}} & ra)
                      | ({W{~(x4f | x6)}} & rt);
  wire flag_d = (x3 & (ra == rc)) | (~x3 & flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0; ibuf <= '0; pc <= '0;
      ra <= '0; rb <= '0; rc <= '0; rt <= '0;
      flag <= 1'b0;
    end else begin
      mar <= mar_d; ibuf <= ibuf_d; pc <= pc_d;
      ra <= ra_d; rb <= rb_d; rc <= rc_d; rt <= rt_d;
      flag <= flag_d;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = ra;
  assign mem_we    = x8;
  assign tstep     = t;
  assign busy      = ~idle;
  assign done      = fin;

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst) $onehot0(t));
  p_one_seq_r8: assert property (@(posedge clk) disable iff (rst) !(sf & sx));
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst) done |=> !busy);
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> (busy && tstep == ($past(tstep) << 1)));
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    f3 |=> pc == $past(pc) + W'(1));
  p_rb_load_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({x1, x4t, x8}) <= 1);
  p_ra_load_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({x2, x7}) <= 1);
  p_rc_load_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({x1, x5f}) <= 1);
  p_rt_load_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({x4f, x6}) <= 1);
  p_swap_r5: assert property (@(posedge clk) disable iff (rst)
    x7 |=> ra == $past(rb));
endmodule

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
  localparam int PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic sel = 1'b0;
  logic [W-1:0] mem_rdata, mem_addr, mem_wdata, pc, ibuf, ra, rb, rc;
  logic mem_we, flag, busy, done;
  logic [8:0] tstep;

  int total = 0;
  int bad = 0;
  logic [W-1:0] dmem [256];
  logic [W-1:0] rmem [256];

  always #(PERIOD/2) clk = ~clk;

  useq_ctrl #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .sel(sel), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .pc(pc), .ibuf(ibuf), .ra(ra), .rb(rb), .rc(rc), .flag(flag),
    .tstep(tstep), .busy(busy), .done(done)
  );

  assign mem_rdata = dmem[mem_addr];
  always @(posedge clk) if (mem_we) dmem[mem_addr] <= mem_wdata;

  initial begin
    for (int i = 0; i < 256; i++) begin
      dmem[i] = (i % 3 == 1) ? 8'd0 : 8'((i * 37 + 11) & 255);
      rmem[i] = dmem[i];
    end
  end

  // reference model
  int step = 0;
  int mseq = 0;
  logic [W-1:0] m_pc = '0, m_mar = '0, m_ib = '0, m_a = '0, m_b = '0, m_c = '0, m_t = '0;
  logic m_f = 1'b0;

  function automatic int last_step(int s);
    return (s == 0) ? 4 : 9;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      step = 0; mseq = 0;
      m_pc = '0; m_mar = '0; m_ib = '0; m_a = '0; m_b = '0; m_c = '0; m_t = '0; m_f = 1'b0;
    end else if (step == 0) begin
      if (start) begin step = 1; mseq = int'(sel); end
    end else begin
      if (mseq == 0) begin
        case (step)
          1: m_mar = m_pc;
          2: m_ib = rmem[m_mar];
          3: m_pc = m_pc + 8'd1;
          default: ;
        endcase
      end else begin
        case (step)
          1: begin m_b = m_ib; m_c = m_pc; end
          2: m_a = m_b + m_c;
          3: m_f = (m_a == m_c);
          4: if (m_f) m_b = m_a >> 1; else m_t = m_a & m_b;
          5: if (!m_f) m_c = m_t | m_c;
          6: m_t = m_a;
          7: m_a = m_b;
          8: begin m_b = m_t; rmem[m_mar] = m_a; end
          default: ;
        endcase
      end
      if (step == last_step(mseq)) step = 0; else step++;
    end
  end

  task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R8", "tstep", 32'(tstep), (step == 0) ? 32'd0 : (32'd1 << (step - 1)));
      chk("R6", "busy", 32'(busy), 32'(step != 0));
      chk("R6", "done", 32'(done), 32'(step != 0 && step == last_step(mseq)));
      chk("R2", "mem_addr", 32'(mem_addr), 32'(m_mar));
      chk("R2", "ibuf", 32'(ibuf), 32'(m_ib));
      chk("R2", "pc", 32'(pc), 32'(m_pc));
      chk("R3", "ra", 32'(ra), 32'(m_a));
      chk("R3", "flag", 32'(flag), 32'(m_f));
      chk("R4", "rb", 32'(rb), 32'(m_b));
      chk("R4", "rc", 32'(rc), 32'(m_c));
      chk("R5", "mem_we", 32'(mem_we), 32'(mseq == 1 && step == 8));
      if (mseq == 1 && step == 8) chk("R5", "mem_wdata", 32'(mem_wdata), 32'(m_a));
    end
  end

  task automatic launch(input logic s);
    @(negedge clk); start = 1'b1; sel = s;
    @(negedge clk); start = 1'b0;
  endtask

  // returns cycles from the first step to done, optionally a stray start at cycle 3
  task automatic run(input logic s, input bit stray, output int n);
    launch(s);
    n = 1;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
      if (stray && n == 3) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: reset state while rst is held
    chk("R1", "tstep", 32'(tstep), 32'd0);
    chk("R1", "busy", 32'(busy), 32'd0);
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "mem_we", 32'(mem_we), 32'd0);
    chk("R1", "regs", {pc, ra, rb, rc}, 32'd0);
    chk("R1", "flag", 32'(flag), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R9: idle cycles with no start leave everything held (model compares each cycle)
    chk("R9", "hold_pc", 32'(pc), 32'd0);

    for (int r = 0; r < 30; r++) begin
      run(1'b0, 1'b0, n);
      chk("R6", "fetch_len", 32'(n), 32'd4);
      @(negedge clk);
      chk("R6", "idle_after_done", 32'(tstep), 32'd0);
      run(1'b1, (r % 4 == 2), n);
      if (r % 4 == 2) chk("R7", "work_len_with_stray_start", 32'(n), 32'd9);
      else chk("R3", "work_len", 32'(n), 32'd9);
      chk("R9", "flag_held", 32'(flag), 32'(m_f));
      if (r % 5 == 4) begin
        // start in the done cycle is ignored, then a start right after idle
        start = 1'b1; sel = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7", "start_in_done_ignored", 32'(busy), 32'd0);
      end
      repeat (r % 3) @(negedge clk);
    end
    // back-to-back work routines without a new fetch
    run(1'b1, 1'b0, n);
    chk("R4", "work_len_again", 32'(n), 32'd9);
    // reset in the middle of a routine
    launch(1'b1);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "mid_reset_idle", 32'(tstep), 32'd0);
    chk("R1", "mid_reset_regs", {pc, ra, rb, rc}, 32'd0);
    run(1'b0, 1'b0, n);
    chk("R2", "fetch_after_reset", 32'(n), 32'd4);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule